// File: doc/BRIEF.md
# HDLC Receive Frame Buffer

This block sits behind a line receiver and turns an HDLC bit stream into whole frames for a host to fetch. One bit arrives per cycle in which `bit_en` is high, least significant bit of each byte first. The block finds the 0x7E flags that open and close each frame, strips the zeros the sender inserted after runs of five ones, and assembles the bytes. It stores every byte between two flags in a circular byte memory, including the two check bytes at the end of the frame. It then appends one status byte that tells whether the frame check sequence was correct.

Each accepted frame gets an entry in a small table that records where its status byte sits. A frame begins one past the previous frame's end, so the table holds only end positions. The host reads one byte per `rd_en` pulse and sees `rd_last` on the status byte. It pulses `rd_frame_done` to release the frame, which also moves the read position to the start of the next frame. Frames that are too short, aborted, not a whole number of bytes long, or that find no room are rolled back. The memory is then left as if they had never arrived.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: Bits are ignored until a flag (0x7E, sent as 0,1,1,1,1,1,1,0 in time order) has been seen. The bytes between an opening and a closing flag form one frame.
- R2: When a 0 follows five consecutive 1 data bits, that 0 is removed before byte assembly. Data bytes of 0xFF and 0x7E are therefore received unchanged.
- R3: Stored bytes appear in arrival order: the data bytes, then the two received check bytes. Each byte is assembled with the first received bit in bit 0.
- R4: After the check bytes, a status byte is stored. It is 00h when the CRC-16 over all frame bytes (initial value FFFFh, reflected polynomial 8408h) leaves the residue F0B8h, and 01h otherwise.
- R5: A frame with fewer than four bytes between its flags (check bytes included) is discarded. The frame count does not change. A four-byte frame is accepted.
- R6: Seven consecutive 1 bits abort the current frame. Its bytes are discarded, the write position returns to the frame start, and nothing is stored until the next flag.
- R7: `frame_count` rises by one for each accepted frame and falls by one on each `rd_frame_done`. `frame_avail` is high exactly when the count is non-zero. Both are 0 after reset.
- R8: `rd_data` shows the byte at the read position of the oldest frame. `rd_last` is high while that byte is the status byte. `rd_frame_done` moves the read position to the first byte of the next frame, skipping any unread bytes.
- R9: A frame that completes while `FT_DEPTH` frames are already pending is dropped. `overflow` is set, and the pending frames stay intact.
- R10: A frame that runs out of byte memory is dropped and `overflow` is set. `overflow` stays high until reset.
- R11: A frame whose closing flag does not fall on a byte boundary is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| rd_en | input | 1 | Advance read position by one byte |
| rd_frame_done | input | 1 | Release the oldest frame |
| rd_data | output | 8 | Byte at the read position |
| rd_last | output | 1 | Read position is on the status byte |
| frame_avail | output | 1 | At least one complete frame is stored |
| frame_count | output | $clog2(FT_DEPTH)+1 | Number of stored frames |
| overflow | output | 1 | Sticky: a frame was lost for lack of room |

## Verification
The bench sends frames of counting bytes, of 0xFF and of 0x7E. Counting bytes confirm byte order and check-byte storage. The 0xFF and 0x7E frames force zero removal at and across byte boundaries, which plain data never reaches. A frame with one corrupted check bit must give status 01h where its clean twin gives 00h. The bench also sends three-byte and four-byte frames to show where the length limit falls, an abort, a frame off by three bits, and a skipped half-read frame. Each of these is followed by a good frame, so a rewind error appears as corrupted bytes in the next frame read. Memory exhaustion and table exhaustion are triggered separately, so each drop path is shown on its own.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] CRC_INIT   = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam int STUFF_ONES      = 5;
  localparam int FLAG_ONES       = 6;
  localparam int MIN_FRAME_BYTES = 4;

  // CRC-16 (reflected) over one byte, LSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = {1'b0, r[15:1]} ^ ({16{r[0] ^ d[i]}} & CRC_POLY_R);
    return r;
  endfunction

  function automatic logic [7:0] status_code(input logic crc_ok);
    return crc_ok ? 8'h00 : 8'h01;
  endfunction
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer import hdlc_rx_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       frame_end,
  output logic       frame_ok,
  output logic       frame_drop
);
  localparam int ALIGN_BITS = STUFF_ONES + 1;   // flag bits that leak in as data
  localparam int NB_W       = $clog2(MIN_FRAME_BYTES + 1);

  logic [2:0]      ones_q;
  logic            in_frame_q;
  logic [2:0]      bitcnt_q;
  logic [7:0]      sh_q;
  logic [NB_W-1:0] nbytes_q;
  logic [15:0]     crc_q;
  logic            is_flag, is_abort, is_data;

  always_comb begin
    is_flag    = bit_en && !bit_in && (ones_q == 3'(FLAG_ONES));
    is_abort   = bit_en &&  bit_in && (ones_q == 3'(FLAG_ONES));
    is_data    = bit_en && in_frame_q && (ones_q < 3'(STUFF_ONES));
    byte_data  = {bit_in, sh_q[7:1]};
    byte_valid = is_data && (bitcnt_q == 3'd7);
    frame_end  = is_flag && in_frame_q && (bitcnt_q == 3'(ALIGN_BITS)) &&
                 (nbytes_q == NB_W'(MIN_FRAME_BYTES));
    frame_drop = in_frame_q && (nbytes_q != '0) && ((is_flag && !frame_end) || is_abort);
    frame_ok   = (crc_q == CRC_GOOD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q     <= '0;
      in_frame_q <= 1'b0;
      bitcnt_q   <= '0;
      sh_q       <= '0;
      nbytes_q   <= '0;
      crc_q      <= CRC_INIT;
    end else if (bit_en) begin
      ones_q <= bit_in ? ((ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1) : 3'd0;
      if (is_flag) begin
        in_frame_q <= 1'b1;
        bitcnt_q   <= '0;
        nbytes_q   <= '0;
        crc_q      <= CRC_INIT;
      end else if (is_abort) begin
        in_frame_q <= 1'b0;
      end else if (is_data) begin
        sh_q     <= byte_data;
        bitcnt_q <= bitcnt_q + 3'd1;
        if (byte_valid) begin
          crc_q <= crc16_byte(crc_q, byte_data);
          if (nbytes_q != NB_W'(MIN_FRAME_BYTES)) nbytes_q <= nbytes_q + NB_W'(1);
        end
      end
    end
  end

  AST_NO_BYTE_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    is_abort |=> !byte_valid); // R6
  AST_END_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_end && (frame_drop || byte_valid))); // R11
endmodule

// File: rtl/hdlc_rx_store.sv
module hdlc_rx_store import hdlc_rx_pkg::*; #(
  parameter int DEPTH    = 256,
  parameter int FT_DEPTH = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      byte_valid,
  input  logic [7:0]                byte_data,
  input  logic                      commit,
  input  logic                      crc_ok,
  input  logic                      drop,
  input  logic                      rd_en,
  input  logic                      rd_done,
  output logic [7:0]                rd_data,
  output logic                      rd_last,
  output logic                      avail,
  output logic [$clog2(FT_DEPTH):0] fcount,
  output logic                      ovf
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int P_W    = ADDR_W + 1;
  localparam int FT_W   = $clog2(FT_DEPTH);
  localparam int FC_W   = FT_W + 1;

  logic [7:0]     mem [DEPTH];
  logic [P_W-1:0] tbl [FT_DEPTH];
  logic [P_W-1:0] wr_ptr, rd_ptr, fstart, used;
  logic [FC_W-1:0] f_wr, f_rd;
  logic           overrun, mem_full, tbl_full, commit_ok, commit_bad, rewind, mem_we;
  logic [7:0]     wdata;

  always_comb begin
    used       = wr_ptr - rd_ptr;
    fcount     = f_wr - f_rd;
    mem_full   = (used == P_W'(DEPTH));
    tbl_full   = (fcount == FC_W'(FT_DEPTH));
    avail      = (fcount != '0);
    commit_ok  = commit && !overrun && !mem_full && !tbl_full;
    commit_bad = commit && !commit_ok;
    rewind     = drop || commit_bad;
    mem_we     = commit_ok || (byte_valid && !mem_full && !rewind);
    wdata      = commit_ok ? status_code(crc_ok) : byte_data;
    rd_data    = mem[rd_ptr[ADDR_W-1:0]];
    rd_last    = avail && (rd_ptr == tbl[f_rd[FT_W-1:0]]);
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_ptr[ADDR_W-1:0]] <= wdata;
    if (commit_ok) tbl[f_wr[FT_W-1:0]] <= wr_ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      fstart  <= '0;
      f_wr    <= '0;
      overrun <= 1'b0;
      ovf     <= 1'b0;
    end else if (rewind) begin
      wr_ptr  <= fstart;
      overrun <= 1'b0;
      if (commit_bad) ovf <= 1'b1;
    end else if (commit_ok) begin
      wr_ptr <= wr_ptr + P_W'(1);
      fstart <= wr_ptr + P_W'(1);
      f_wr   <= f_wr + FC_W'(1);
    end else if (byte_valid) begin
      if (mem_full) overrun <= 1'b1;
      else          wr_ptr  <= wr_ptr + P_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      f_rd   <= '0;
    end else if (rd_done && avail) begin
      rd_ptr <= tbl[f_rd[FT_W-1:0]] + P_W'(1);
      f_rd   <= f_rd + FC_W'(1);
    end else if (rd_en && avail) begin
      rd_ptr <= rd_ptr + P_W'(1);
    end
  end

  AST_MEM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used <= P_W'(DEPTH)); // R10
  AST_TBL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fcount <= FC_W'(FT_DEPTH)); // R9
  AST_REWIND_START: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (wr_ptr == $past(fstart))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R10
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ok && !(rd_done && avail)) |=> (fcount == $past(fcount) + FC_W'(1))); // R7
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int DEPTH    = 256,
  parameter int FT_DEPTH = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bit_en,
  input  logic                      bit_in,
  input  logic                      rd_en,
  input  logic                      rd_frame_done,
  output logic [7:0]                rd_data,
  output logic                      rd_last,
  output logic                      frame_avail,
  output logic [$clog2(FT_DEPTH):0] frame_count,
  output logic                      overflow
);
  logic       ev_byte, ev_end, ev_ok, ev_drop;
  logic [7:0] ev_data;

  hdlc_rx_deframer u_deframer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .byte_valid(ev_byte), .byte_data(ev_data),
    .frame_end(ev_end), .frame_ok(ev_ok), .frame_drop(ev_drop)
  );

  hdlc_rx_store #(.DEPTH(DEPTH), .FT_DEPTH(FT_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .byte_valid(ev_byte), .byte_data(ev_data),
    .commit(ev_end), .crc_ok(ev_ok), .drop(ev_drop),
    .rd_en(rd_en), .rd_done(rd_frame_done),
    .rd_data(rd_data), .rd_last(rd_last), .avail(frame_avail),
    .fcount(frame_count), .ovf(overflow)
  );

  AST_AVAIL_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_avail == (frame_count != '0)); // R7
endmodule

// File: tb/tb_hdlc_rx_fifo.sv
`timescale 1ns/1ps
module tb_hdlc_rx_fifo;
  localparam int DEPTH = 32;
  localparam int FT_DEPTH = 4;

  logic clk = 0, rst_n = 0, bit_en = 0, bit_in = 0, rd_en = 0, rd_frame_done = 0;
  logic [7:0] rd_data;
  logic rd_last, frame_avail, overflow;
  logic [$clog2(FT_DEPTH):0] frame_count;

  int n_chk = 0, n_fail = 0, ones_run = 0;
  bit finished = 0;
  logic [8:0] exp_q[$];

  hdlc_rx_fifo #(.DEPTH(DEPTH), .FT_DEPTH(FT_DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .rd_en(rd_en), .rd_frame_done(rd_frame_done), .rd_data(rd_data),
    .rd_last(rd_last), .frame_avail(frame_avail), .frame_count(frame_count),
    .overflow(overflow));

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fcs_step(logic [15:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  function automatic logic [7:0] gen(int mode, int seed, int i);
    case (mode)
      1: return 8'hFF;
      2: return 8'h7E;
      default: return 8'(seed + i * 29);
    endcase
  endfunction

  task automatic raw_bit(logic b);
    bit_en = 1; bit_in = b;
    @(negedge clk);
    bit_en = 0;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) raw_bit(8'h7E >> i);
    ones_run = 0;
  endtask

  task automatic stuffed_bit(logic b);
    raw_bit(b);
    ones_run = b ? ones_run + 1 : 0;
    if (ones_run == 5) begin raw_bit(1'b0); ones_run = 0; end
  endtask

  task automatic stuffed_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) stuffed_bit(b[i]);
  endtask

  // driver: sends one framed message and pushes what should be stored
  task automatic send_frame(int n, int mode, int seed, bit bad, bit keep);
    logic [15:0] c = 16'hFFFF, fcs;
    send_flag();
    for (int i = 0; i < n; i++) begin
      c = fcs_step(c, gen(mode, seed, i));
      stuffed_byte(gen(mode, seed, i));
      if (keep) exp_q.push_back({1'b0, gen(mode, seed, i)});
    end
    fcs = ~c;
    if (bad) fcs[3] = ~fcs[3];
    stuffed_byte(fcs[7:0]);
    stuffed_byte(fcs[15:8]);
    send_flag();
    if (keep) begin
      exp_q.push_back({1'b0, fcs[7:0]});
      exp_q.push_back({1'b0, fcs[15:8]});
      exp_q.push_back({1'b1, bad ? 8'h01 : 8'h00});
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(bit done);
    if (done) rd_frame_done = 1; else rd_en = 1;
    @(negedge clk);
    rd_frame_done = 0; rd_en = 0;
  endtask

  // monitor: pops expected bytes and compares them with the read port
  task automatic read_frame(string req);
    logic [8:0] e;
    bit fin = 0;
    check({req, " frame_avail"}, 16'(frame_avail), 16'd1);
    while (!fin) begin
      if (exp_q.size() == 0) begin
        check({req, " queue underrun"}, 16'd1, 16'd0);
        pulse(1); fin = 1;
      end else begin
        e = exp_q.pop_front();
        check({req, " byte"}, 16'(rd_data), 16'(e[7:0]));
        check("R8 rd_last", 16'(rd_last), 16'(e[8]));
        if (e[8] || rd_last) begin pulse(1); fin = 1; end
        else pulse(0);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    if (!finished) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 reset count", 16'(frame_count), 16'd0);
    check("R7 reset avail", 16'(frame_avail), 16'd0);
    check("R10 reset overflow", 16'(overflow), 16'd0);

    // R1: noise before first flag stores nothing
    for (int i = 0; i < 24; i++) raw_bit(logic'((i * 5 + 3) % 3 == 0));
    repeat (10) raw_bit(1'b1);
    repeat (3) @(negedge clk);
    check("R1 pre-flag count", 16'(frame_count), 16'd0);

    send_frame(6, 0, 17, 0, 1);
    check("R7 count after one", 16'(frame_count), 16'd1);
    read_frame("R3");
    check("R7 count after done", 16'(frame_count), 16'd0);

    send_frame(5, 1, 0, 0, 1);
    read_frame("R2 ones");
    send_frame(5, 2, 0, 0, 1);
    read_frame("R2 flagdata");

    send_frame(4, 0, 90, 1, 1);
    read_frame("R4 bad crc");

    // R5: three-byte frame discarded, four-byte frame kept
    send_frame(1, 0, 5, 0, 0);
    check("R5 short count", 16'(frame_count), 16'd0);
    send_frame(2, 0, 6, 0, 1);
    check("R5 min count", 16'(frame_count), 16'd1);
    read_frame("R5");

    // R6: abort mid frame
    send_flag();
    stuffed_byte(8'h11); stuffed_byte(8'h22); stuffed_byte(8'h33); stuffed_byte(8'h44);
    repeat (8) raw_bit(1'b1);
    stuffed_byte(8'h55); stuffed_byte(8'h66); stuffed_byte(8'h77); stuffed_byte(8'h88);
    repeat (3) @(negedge clk);
    check("R6 abort count", 16'(frame_count), 16'd0);
    send_frame(3, 0, 41, 0, 1);
    check("R6 next count", 16'(frame_count), 16'd1);
    read_frame("R6");

    // R11: closing flag off by three bits
    send_flag();
    for (int i = 0; i < 5; i++) stuffed_byte(gen(0, 3, i));
    repeat (3) stuffed_bit(1'b0);
    send_flag();
    repeat (3) @(negedge clk);
    check("R11 misaligned count", 16'(frame_count), 16'd0);
    send_frame(4, 0, 77, 0, 1);
    read_frame("R11 next");

    // R8: skip a partially read frame
    send_frame(8, 0, 100, 0, 0);
    send_frame(3, 0, 200, 0, 1);
    check("R8 two pending", 16'(frame_count), 16'd2);
    check("R8 first byte", 16'(rd_data), 16'(gen(0, 100, 0)));
    pulse(0);
    check("R8 second byte", 16'(rd_data), 16'(gen(0, 100, 1)));
    pulse(1);
    check("R8 count after skip", 16'(frame_count), 16'd1);
    read_frame("R8 after skip");

    // R10: frame too large for memory
    send_frame(40, 0, 9, 0, 0);
    check("R10 count", 16'(frame_count), 16'd0);
    check("R10 overflow", 16'(overflow), 16'd1);
    send_frame(3, 0, 61, 0, 1);
    read_frame("R10 next");

    // R9: table full
    for (int k = 0; k < FT_DEPTH; k++) send_frame(2, 0, 10 + k, 0, 1);
    send_frame(2, 0, 99, 0, 0);
    check("R9 count held", 16'(frame_count), 16'(FT_DEPTH));
    check("R9 overflow", 16'(overflow), 16'd1);
    for (int k = 0; k < FT_DEPTH; k++) read_frame("R9");
    check("R9 drained", 16'(frame_count), 16'd0);
    check("R9 queue empty", 16'(exp_q.size()), 16'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule